// File: doc/BRIEF.md
# Interrupt-Wake Power-Down Controller

This block holds the processor core in a low-power state and decides when its clock runs. Software asks for power-down by writing a command word. The request waits until the current bus cycle has finished, which `bus_idle` signals. The block then drops the core clock enable. Any pending enabled interrupt, reported as a single line by the interrupt controller, brings the clock back on the next edge. No reset is involved, so the core picks up where it stopped and services that interrupt in the usual way.

A second writable register holds one clock-enable bit for each peripheral module. Software uses it to stop individual peripherals. These bits are separate from the core power-down and keep their value through sleep and wake. The clock-gating cells and the interrupt prioritisation lie outside this block. It only produces the enable levels and a status bit that shows whether the core is asleep.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset, `core_clk_en` is 1, `pd_status` is 0 and every bit of `periph_clk_en` is 1.
- R2: A write to address 0 with data bit 0 set, while the core runs, arms a power-down request. `core_clk_en` stays 1 on the following cycle.
- R3: While a request is armed and no interrupt is pending, `bus_idle` high at a clock edge makes `core_clk_en` 0 and `pd_status` 1 after that edge.
- R4: While a request is armed, `bus_idle` low and no interrupt pending, the core stays clocked and the request stays armed.
- R5: While the core is asleep, `irq_pending` high at a clock edge makes `core_clk_en` 1 and `pd_status` 0 after that same edge.
- R6: An interrupt pending while a request is armed cancels the request, even if `bus_idle` is also high. The core stays clocked and does not enter power-down until a new command is written.
- R7: While the core is asleep and no interrupt is pending, it stays asleep whatever `bus_idle` does and whatever is written to address 0.
- R8: A write to address 1 loads `wr_data[N_PERIPH-1:0]` into `periph_clk_en` at that edge, in any power state. Bit i enables peripheral i.
- R9: A write to address 0 with data bit 0 clear changes nothing, and so does a write to address 2 or 3.
- R10: `periph_clk_en` changes only through writes to address 1. Entering or leaving power-down leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock of the controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 is the command, 1 is the peripheral enables |
| wr_data | input | N_PERIPH | Write data |
| bus_idle | input | 1 | High when no bus cycle is in progress |
| irq_pending | input | 1 | High while any enabled interrupt is pending |
| core_clk_en | output | 1 | Clock enable for the core |
| periph_clk_en | output | N_PERIPH | Clock enable for each peripheral |
| pd_status | output | 1 | High while the core is powered down |

## Verification
Every result in this block appears one clock edge after the inputs that cause it. A command write arms the request after its edge, and an idle bus puts the core to sleep after the next edge. A pending interrupt restores `core_clk_en` after the edge at which it is seen, and a mask write shows on `periph_clk_en` after its own edge. The bench changes inputs on the falling edge and predicts the state after the coming rising edge from its own model. It compares all three outputs 2 ns after that rising edge. Each cycle is therefore judged exactly one register stage after its stimulus, with nothing sampled at an edge.

// File: rtl/pwrdn_ctrl_pkg.sv
package pwrdn_ctrl_pkg;

  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_ARMED = 2'd1,
    PD_SLEEP = 2'd2
  } pd_state_e;

  localparam int unsigned REG_CMD  = 0;
  localparam int unsigned REG_MASK = 1;

  // Power-state step: an interrupt outranks bus idle while armed.
  function automatic pd_state_e pd_step(pd_state_e cur, logic arm_req,
                                        logic idle, logic irq);
    pd_state_e nxt;
    case (cur)
      PD_RUN:   nxt = arm_req ? PD_ARMED : PD_RUN;
      PD_ARMED: nxt = irq ? PD_RUN : (idle ? PD_SLEEP : PD_ARMED);
      PD_SLEEP: nxt = irq ? PD_RUN : PD_SLEEP;
      default:  nxt = PD_RUN;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pwrdn_wr_decode.sv
module pwrdn_wr_decode #(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              cmd_bit,
  output logic              arm_cmd,
  output logic              mask_wr
);
  import pwrdn_ctrl_pkg::*;

  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(REG_CMD);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_MASK);

  always_comb begin
    arm_cmd = wr_en && (wr_addr == A_CMD) && cmd_bit;
    mask_wr = wr_en && (wr_addr == A_MASK);
  end

endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_cmd,
  input  logic bus_idle,
  input  logic irq_pending,
  output logic armed,
  output logic asleep
);
  import pwrdn_ctrl_pkg::*;

  pd_state_e state_q;
  pd_state_e state_d;

  always_comb state_d = pd_step(state_q, arm_cmd, bus_idle, irq_pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PD_RUN;
    else        state_q <= state_d;
  end

  assign armed  = (state_q == PD_ARMED);
  assign asleep = (state_q == PD_SLEEP);

  AST_SLEEP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(bus_idle) && $past(armed)); // R3
  AST_WAIT_FOR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !bus_idle && !irq_pending) |=> armed); // R4
  AST_WAKE_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && irq_pending) |=> !asleep && !armed); // R5
  AST_IRQ_CANCELS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && irq_pending) |=> !asleep && !armed); // R6
  AST_HOLD_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !irq_pending) |=> asleep); // R7
  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed, asleep})); // R2

endmodule

// File: rtl/pwrdn_periph_gate.sv
module pwrdn_periph_gate #(
  parameter int unsigned N_PERIPH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mask_wr,
  input  logic [N_PERIPH-1:0] mask_data,
  output logic [N_PERIPH-1:0] periph_en
);

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       periph_en[i] <= 1'b1;
      else if (mask_wr) periph_en[i] <= mask_data[i];
    end
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> periph_en == $past(mask_data)); // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(periph_en)); // R10

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl #(
  parameter int unsigned N_PERIPH = 8,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [N_PERIPH-1:0] wr_data,
  input  logic                bus_idle,
  input  logic                irq_pending,
  output logic                core_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                pd_status
);

  logic arm_cmd;
  logic mask_wr;
  logic armed;
  logic asleep;

  pwrdn_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmd_bit (wr_data[0]),
    .arm_cmd (arm_cmd),
    .mask_wr (mask_wr)
  );

  pwrdn_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_cmd     (arm_cmd),
    .bus_idle    (bus_idle),
    .irq_pending (irq_pending),
    .armed       (armed),
    .asleep      (asleep)
  );

  pwrdn_periph_gate #(.N_PERIPH(N_PERIPH)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr   (mask_wr),
    .mask_data (wr_data),
    .periph_en (periph_clk_en)
  );

  assign core_clk_en = !asleep;
  assign pd_status   = asleep;

  AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    pd_status != core_clk_en); // R5
  AST_NO_SLEEP_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !asleep) |=> !asleep); // R2
  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !asleep && !arm_cmd) |=> !armed && !asleep); // R9

endmodule

// File: tb/pwrdn_ctrl_bench.sv
module pwrdn_ctrl_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic         bus_idle = 1'b0;
  logic         irq_pending = 1'b0;
  logic         core_clk_en;
  logic [N-1:0] periph_clk_en;
  logic         pd_status;

  int checks = 0;
  int errors = 0;
  int m_state = 0;            // 0 running, 1 armed, 2 asleep
  logic [N-1:0] m_mask = '1;
  bit done = 0;

  always #5 clk = ~clk;

  pwrdn_ctrl #(.N_PERIPH(N), .ADDR_W(2)) u_pwrdn_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bus_idle(bus_idle), .irq_pending(irq_pending),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .pd_status(pd_status)
  );

  function automatic int model_next(int s, bit we, logic [1:0] a,
                                    logic [N-1:0] d, bit idle, bit irq);
    if (s == 2) return irq ? 0 : 2;
    if (s == 1) begin
      if (irq) return 0;
      return idle ? 2 : 1;
    end
    return (we && a == 2'd0 && d[0]) ? 1 : 0;
  endfunction

  function automatic string pick_tag(int s, bit we, logic [1:0] a,
                                     logic [N-1:0] d, bit idle, bit irq);
    if (s == 2) return irq ? "R5" : "R7";
    if (s == 1) return irq ? "R6" : (idle ? "R3" : "R4");
    if (we && (a >= 2'd2 || (a == 2'd0 && !d[0]))) return "R9";
    return "R2";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit we, logic [1:0] a, logic [N-1:0] d, bit idle, bit irq);
    string ctag;
    string mtag;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; bus_idle = idle; irq_pending = irq;
    ctag = pick_tag(m_state, we, a, d, idle, irq);
    mtag = (we && a == 2'd1) ? "R8" : ((we && a >= 2'd2) ? "R9" : "R10");
    m_state = model_next(m_state, we, a, d, idle, irq);
    if (we && a == 2'd1) m_mask = d;
    @(posedge clk);
    #2;
    check(ctag, "core_clk_en", int'(core_clk_en), (m_state == 2) ? 0 : 1);
    check(ctag, "pd_status", int'(pd_status), (m_state == 2) ? 1 : 0);
    check(mtag, "periph_clk_en", int'(periph_clk_en), int'(m_mask));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1", "core_clk_en", int'(core_clk_en), 1);
    check("R1", "pd_status", int'(pd_status), 0);
    check("R1", "periph_clk_en", int'(periph_clk_en), 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "periph_clk_en after release", int'(periph_clk_en), 8'hFF);

    // R2 arm, R4 wait for busy bus, R3 enter sleep
    step(1, 2'd0, 8'h01, 0, 0);
    step(0, 2'd0, 8'h00, 0, 0);
    step(0, 2'd0, 8'h00, 1, 0);
    // R7 stays asleep through idle changes and command writes
    step(1, 2'd0, 8'h01, 1, 0);
    step(0, 2'd0, 8'h00, 0, 0);
    // R8 mask write while asleep
    step(1, 2'd1, 8'h5A, 1, 0);
    // R5 wake, R10 mask kept
    step(0, 2'd0, 8'h00, 1, 1);
    step(0, 2'd0, 8'h00, 1, 0);
    // R6 interrupt cancels an armed request even with idle bus
    step(1, 2'd0, 8'h01, 0, 0);
    step(0, 2'd0, 8'h00, 1, 1);
    step(0, 2'd0, 8'h00, 1, 0);
    // R9 ignored writes
    step(1, 2'd0, 8'hFE, 1, 0);
    step(1, 2'd2, 8'h00, 1, 0);
    step(1, 2'd3, 8'h0F, 1, 0);
    // immediate entry: arm with idle already high
    step(1, 2'd0, 8'h01, 1, 0);
    step(0, 2'd0, 8'h00, 1, 0);
    step(0, 2'd0, 8'h00, 0, 1);

    for (int i = 0; i < 4000; i++) begin
      bit we;
      logic [1:0] a;
      logic [N-1:0] d;
      bit idle;
      bit irq;
      we   = ($urandom % 3) == 0;
      a    = 2'($urandom % 4);
      d    = N'($urandom);
      idle = ($urandom % 2) == 0;
      irq  = ($urandom % 7) == 0;
      step(we, a, d, idle, irq);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule